// File: doc/BRIEF.md
# Busy/Done Device Controller Register Block

This block is the register front end that a processor uses to drive a simple peripheral. Software sees a command register, a status register and a small bank of data registers on a single-cycle write bus with a combinational read port. A command write launches the device with a one-cycle start pulse. The device later returns a one-cycle finish pulse that may carry an error code. The controller's state is held entirely in the two status flags busy and done.

Software loads its operands into the data registers while the controller is idle, then writes a command. It then waits for the interrupt-pending output, or polls done. When the operation is complete, a status write acknowledges it and returns the controller to idle. The controller drops a command or a data write that arrives at the wrong moment, and it flags a command refused in this way in the error field.

Top module: `devctl_regs`

## Requirements
- R1: After reset the status register reads 0, irq_pending and dev_start are 0, and every data register reads 0.
- R2: A write to address 0 while idle (busy=0, done=0) sets busy. In the cycle after the write, dev_start is high for exactly one cycle, with dev_cmd equal to the low CMD_W bits written. Address 0 reads back the last accepted command.
- R3: The status word at address 1 holds busy in bit 0, done in bit 1 and the error code in bits 2 and up. A finish pulse while busy clears busy, sets done and latches dev_err into the error field on the next clock edge.
- R4: irq_pending rises only in the cycle in which busy has just fallen from 1 to 0.
- R5: A status write with bit 1 equal to 0 while done is set clears done, the error field and irq_pending on the same edge. A status write with bit 1 equal to 1 changes nothing.
- R6: A command write while busy or done is set produces no start pulse and does not change busy, done or the command register. It sets the error field to all ones (7 with the default width).
- R7: Data registers live at addresses 2 to 2+NUM_DATA-1 and read back in every state. Writes to them take effect only while the controller is idle.
- R8: A finish pulse while the controller is not busy has no effect on status or irq_pending.
- R9: busy and done are never both 1.
- R10: When a command write and a finish pulse land in the same cycle while busy, the operation completes and the device's error code is kept. The command is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address for read and write |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| irq_pending | output | 1 | Interrupt pending, held until acknowledge |
| dev_start | output | 1 | One-cycle launch pulse to the device |
| dev_cmd | output | CMD_W | Command code presented to the device |
| dev_wdata | output | DATA_W | Contents of data register 0 |
| dev_finish | input | 1 | One-cycle completion pulse from the device |
| dev_err | input | ERR_W | Completion code, valid with dev_finish |

## Verification
A refused command write and a device completion can fall in the same clock cycle, and both want to write the error field. The bench provokes this by launching a command and then driving a second command write together with a finish pulse that carries a nonzero code. It judges the outcome at the ports: the status must read done with the device's code, irq_pending must be set, no second start pulse may appear, and address 0 must still return the first command.

// File: rtl/devctl_pkg.sv
package devctl_pkg;
  // State encoding is the {busy, done} pair itself
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_FIN  = 2'b01,
    ST_WORK = 2'b10
  } ctl_state_e;

  localparam int unsigned CMD_ADDR     = 0;
  localparam int unsigned STAT_ADDR    = 1;
  localparam int unsigned DATA_BASE    = 2;
  localparam int unsigned STAT_BUSY    = 0;
  localparam int unsigned STAT_DONE    = 1;
  localparam int unsigned STAT_ERR_LSB = 2;
endpackage

// File: rtl/devctl_rst_sync.sv
module devctl_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/devctl_status_fsm.sv
module devctl_status_fsm
  import devctl_pkg::*;
#(
  parameter int unsigned ERR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr_i,
  input  logic             ack_wr_i,
  input  logic             fin_i,
  input  logic [ERR_W-1:0] fin_err_i,
  output ctl_state_e       state_o,
  output logic [ERR_W-1:0] err_o,
  output logic             irq_o,
  output logic             accept_o
);
  localparam logic [ERR_W-1:0] ERR_REJECT = '1;

  ctl_state_e       state_q, state_d;
  logic [ERR_W-1:0] err_q, err_d;
  logic             irq_q, irq_d;
  logic             upd_en;

  assign accept_o = cmd_wr_i && (state_q == ST_IDLE);
  assign upd_en   = cmd_wr_i || ack_wr_i || fin_i;

  always_comb begin
    state_d = state_q;
    err_d   = err_q;
    irq_d   = irq_q;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_wr_i) state_d = ST_WORK;
      end
      ST_WORK: begin
        if (fin_i) begin
          state_d = ST_FIN;
          err_d   = fin_err_i;
          irq_d   = 1'b1;
        end else if (cmd_wr_i) begin
          err_d = ERR_REJECT;
        end
      end
      ST_FIN: begin
        if (ack_wr_i) begin
          state_d = ST_IDLE;
          err_d   = '0;
          irq_d   = 1'b0;
        end else if (cmd_wr_i) begin
          err_d = ERR_REJECT;
        end
      end
      default: begin
        state_d = ST_IDLE;
        err_d   = '0;
        irq_d   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= '0;
      irq_q   <= 1'b0;
    end else if (upd_en) begin
      state_q <= state_d;
      err_q   <= err_d;
      irq_q   <= irq_d;
    end
  end

  assign state_o = state_q;
  assign err_o   = err_q;
  assign irq_o   = irq_q;

  assert_no_undef_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != 2'b11);

  assert_reject_keeps_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_i && state_q == ST_FIN && !ack_wr_i) |=> state_q == ST_FIN);
endmodule

// File: rtl/devctl_launch.sv
module devctl_launch #(
  parameter int unsigned CMD_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic [CMD_W-1:0] cmd_i,
  output logic             start_o,
  output logic [CMD_W-1:0] cmd_o
);
  logic             start_q;
  logic [CMD_W-1:0] cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= accept_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cmd_q <= '0;
    else if (accept_i) cmd_q <= cmd_i;
  end

  assign start_o = start_q;
  assign cmd_o   = cmd_q;

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);

  assert_cmd_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_i |=> $stable(cmd_q));
endmodule

// File: rtl/devctl_data_bank.sv
module devctl_data_bank #(
  parameter int unsigned NUM_DATA = 4,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned IDX_W    = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en_i,
  input  logic [IDX_W-1:0]               wr_idx_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic                           idle_i,
  output logic [NUM_DATA-1:0][DATA_W-1:0] regs_o
);
  logic [NUM_DATA-1:0][DATA_W-1:0] regs_q;

  for (genvar g = 0; g < NUM_DATA; g++) begin : g_reg
    logic load_en;
    assign load_en = wr_en_i && idle_i && (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       regs_q[g] <= '0;
      else if (load_en) regs_q[g] <= wdata_i;
    end
  end

  assign regs_o = regs_q;

  assert_locked_when_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_i |=> $stable(regs_q));
endmodule

// File: rtl/devctl_regs.sv
module devctl_regs
  import devctl_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_DATA = 4,
  parameter int unsigned CMD_W    = 4,
  parameter int unsigned ERR_W    = 3,
  parameter int unsigned ADDR_W   = $clog2(DATA_BASE + NUM_DATA)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_pending,
  output logic              dev_start,
  output logic [CMD_W-1:0]  dev_cmd,
  output logic [DATA_W-1:0] dev_wdata,
  input  logic              dev_finish,
  input  logic [ERR_W-1:0]  dev_err
);
  localparam int unsigned IDX_W = (NUM_DATA > 1) ? $clog2(NUM_DATA) : 1;
  localparam logic [ADDR_W:0] DATA_END = (ADDR_W + 1)'(DATA_BASE + NUM_DATA);

  logic                            rst_sn;
  logic                            hit_cmd, hit_stat, hit_data;
  logic                            cmd_wr, ack_wr, data_wr, accept;
  logic [ADDR_W-1:0]               data_off;
  logic [IDX_W-1:0]                data_idx;
  ctl_state_e                      state;
  logic [1:0]                      st_bits;
  logic                            busy, done;
  logic [ERR_W-1:0]                err;
  logic [NUM_DATA-1:0][DATA_W-1:0] regs;

  devctl_rst_sync u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sn)
  );

  // Address decode
  assign hit_cmd  = (bus_addr == ADDR_W'(CMD_ADDR));
  assign hit_stat = (bus_addr == ADDR_W'(STAT_ADDR));
  assign hit_data = (bus_addr >= ADDR_W'(DATA_BASE)) && ({1'b0, bus_addr} < DATA_END);
  assign data_off = bus_addr - ADDR_W'(DATA_BASE);
  assign data_idx = data_off[IDX_W-1:0];

  assign cmd_wr  = bus_wen && hit_cmd;
  assign ack_wr  = bus_wen && hit_stat && !bus_wdata[STAT_DONE];
  assign data_wr = bus_wen && hit_data;

  devctl_status_fsm #(.ERR_W(ERR_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sn),
    .cmd_wr_i  (cmd_wr),
    .ack_wr_i  (ack_wr),
    .fin_i     (dev_finish),
    .fin_err_i (dev_err),
    .state_o   (state),
    .err_o     (err),
    .irq_o     (irq_pending),
    .accept_o  (accept)
  );

  assign st_bits = state;
  assign busy    = st_bits[1];
  assign done    = st_bits[0];

  devctl_launch #(.CMD_W(CMD_W)) u_launch (
    .clk      (clk),
    .rst_n    (rst_sn),
    .accept_i (accept),
    .cmd_i    (bus_wdata[CMD_W-1:0]),
    .start_o  (dev_start),
    .cmd_o    (dev_cmd)
  );

  devctl_data_bank #(
    .NUM_DATA (NUM_DATA),
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_sn),
    .wr_en_i  (data_wr),
    .wr_idx_i (data_idx),
    .wdata_i  (bus_wdata),
    .idle_i   (state == ST_IDLE),
    .regs_o   (regs)
  );

  assign dev_wdata = regs[0];

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (hit_cmd) begin
      bus_rdata[CMD_W-1:0] = dev_cmd;
    end else if (hit_stat) begin
      bus_rdata[STAT_BUSY]                = busy;
      bus_rdata[STAT_DONE]                = done;
      bus_rdata[STAT_ERR_LSB +: ERR_W]    = err;
    end else if (hit_data) begin
      bus_rdata = regs[data_idx];
    end
  end

  assert_irq_on_busy_fall_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(irq_pending) |-> $fell(busy));

  assert_irq_needs_done_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    irq_pending |-> done);

  assert_start_with_busy_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(busy) |-> dev_start);
endmodule

// File: tb/devctl_regs_tb_top.sv
`timescale 1ns/1ps
module devctl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  bus_addr;
  logic        bus_wen;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        irq_pending;
  logic        dev_start;
  logic [3:0]  dev_cmd;
  logic [15:0] dev_wdata;
  logic        dev_finish;
  logic [2:0]  dev_err;

  int checks = 0;
  int fails  = 0;
  logic       mon_on = 1'b0;
  logic [3:0] exp_q[$];

  always #4 clk = ~clk;

  devctl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pending(irq_pending),
    .dev_start(dev_start), .dev_cmd(dev_cmd), .dev_wdata(dev_wdata),
    .dev_finish(dev_finish), .dev_err(dev_err)
  );

  // Monitor: every start pulse must match the next expected command
  always @(negedge clk) begin
    if (mon_on && dev_start) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R6 unexpected start, actual cmd=%0h expected none", dev_cmd);
      end else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        if (dev_cmd !== e) begin
          fails++;
          $display("FAIL R2 dev_cmd actual=%0h expected=%0h", dev_cmd, e);
        end
      end
    end
  end

  task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic issue_cmd(input logic [3:0] c);
    exp_q.push_back(c);
    bus_wr(3'd0, {12'h0, c});
  endtask

  task automatic dev_done(input logic [2:0] e);
    dev_finish = 1'b1; dev_err = e;
    @(posedge clk); @(negedge clk);
    dev_finish = 1'b0; dev_err = '0;
  endtask

  task automatic collide(input logic [3:0] c, input logic [2:0] e);
    bus_addr = 3'd0; bus_wdata = {12'h0, c}; bus_wen = 1'b1;
    dev_finish = 1'b1; dev_err = e;
    @(posedge clk); @(negedge clk);
    bus_wen = 1'b0; dev_finish = 1'b0; dev_err = '0;
  endtask

  task automatic chk_reg(input logic [2:0] a, input logic [15:0] exp, input string tag);
    bus_addr = a;
    #1;
    checks++;
    if (bus_rdata !== exp) begin
      fails++;
      $display("FAIL %s addr=%0d actual=%04h expected=%04h", tag, a, bus_rdata, exp);
    end
    if (a == 3'd1) begin
      checks++;
      if (bus_rdata[1:0] === 2'b11) begin
        fails++;
        $display("FAIL R9 busy/done actual=11 expected not 11");
      end
    end
  endtask

  task automatic chk_bit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wen = 1'b0; bus_wdata = '0;
    dev_finish = 1'b0; dev_err = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mon_on = 1'b1;

    // R1 reset state
    chk_reg(3'd1, 16'h0000, "R1 status");
    chk_bit(irq_pending, 1'b0, "R1 irq");
    chk_bit(dev_start, 1'b0, "R1 start");
    for (int i = 0; i < 4; i++) chk_reg(3'(2 + i), 16'h0000, "R1 data");

    // R7 data write while idle
    bus_wr(3'd2, 16'hA5A5);
    chk_reg(3'd2, 16'hA5A5, "R7 idle write");

    // R2 launch
    issue_cmd(4'h3);
    chk_reg(3'd1, 16'h0001, "R2 busy");
    chk_reg(3'd0, 16'h0003, "R2 cmd readback");
    chk_reg(3'd2, 16'hA5A5, "R7 read while busy");

    // R7 data write while busy dropped
    bus_wr(3'd3, 16'h5555);
    chk_reg(3'd3, 16'h0000, "R7 busy write");

    // R6 command while busy
    bus_wr(3'd0, 16'h0005);
    chk_reg(3'd1, 16'h001D, "R6 busy reject");
    chk_reg(3'd0, 16'h0003, "R6 cmd kept");

    // R3 R4 completion
    chk_bit(irq_pending, 1'b0, "R4 irq before finish");
    dev_done(3'd0);
    chk_reg(3'd1, 16'h0002, "R3 done");
    chk_bit(irq_pending, 1'b1, "R4 irq");

    // R6 command while done
    bus_wr(3'd0, 16'h0006);
    chk_reg(3'd1, 16'h001E, "R6 done reject");
    chk_bit(irq_pending, 1'b1, "R6 irq kept");

    // R7 data write while done dropped
    bus_wr(3'd4, 16'h1234);
    chk_reg(3'd4, 16'h0000, "R7 done write");

    // R5 status write with bit1=1 ignored
    bus_wr(3'd1, 16'h0002);
    chk_reg(3'd1, 16'h001E, "R5 no ack");

    // R8 finish while done ignored
    dev_done(3'd4);
    chk_reg(3'd1, 16'h001E, "R8 finish in done");

    // R5 acknowledge
    bus_wr(3'd1, 16'h0000);
    chk_reg(3'd1, 16'h0000, "R5 ack");
    chk_bit(irq_pending, 1'b0, "R5 irq clear");

    // R8 finish while idle ignored
    dev_done(3'd2);
    chk_reg(3'd1, 16'h0000, "R8 finish in idle");
    chk_bit(irq_pending, 1'b0, "R8 irq");

    // R3 error code latched
    issue_cmd(4'hA);
    dev_done(3'd5);
    chk_reg(3'd1, 16'h0016, "R3 err latch");
    chk_reg(3'd0, 16'h000A, "R2 cmd readback");
    bus_wr(3'd1, 16'h0000);
    chk_reg(3'd1, 16'h0000, "R5 ack");

    // R10 collision of command write and finish
    issue_cmd(4'h1);
    collide(4'h9, 3'd3);
    chk_reg(3'd1, 16'h000E, "R10 status");
    chk_bit(irq_pending, 1'b1, "R10 irq");
    chk_reg(3'd0, 16'h0001, "R10 cmd kept");
    bus_wr(3'd1, 16'h0000);
    chk_reg(3'd1, 16'h0000, "R5 ack");

    // R7 idle write after activity
    bus_wr(3'd5, 16'hBEEF);
    chk_reg(3'd5, 16'hBEEF, "R7 idle write");
    chk_reg(3'd2, 16'hA5A5, "R7 data0 kept");

    repeat (2) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R2 missing start pulses actual=%0d expected=0", exp_q.size());
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule